// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives a single pulse-width-modulated output whose period and duty cycle are both programmable. The time base is 10 bits wide: an 8-bit coarse counter extended below by a 2-bit sub-count. Each cycle in which `step_en` is high advances the time base by one. Software, or a neighbouring block, sets the period with an 8-bit value. It sets the duty with an 8-bit high part plus a 2-bit low part that sits inside a small control word. The control word also carries a 4-bit mode field that turns PWM operation on or off.

The duty value that is written goes into a master register. It is copied into a slave register only when a period ends. Because of this, the compare logic always sees a value that is consistent for the whole period, and rewriting the duty never produces a truncated or doubled pulse. At each period boundary the block also emits a one-cycle strobe. This strobe can feed a timer interrupt or a postscaler.

Top module: `pwm10_dbuf`

## Requirements
- R1: While `rst_n` is low and after its release, `pwm_out` and `period_strobe` are 0. The period register, the duty registers and the time base all reset to 0.
- R2: Each cycle with `step_en` high advances the 10-bit time base by one. The low 2 bits form the sub-count. A period ends on the step where the sub-count is 3 and the coarse count equals the period value P. That step clears the time base, so a period lasts 4·(P+1) steps. `period_strobe` is high for exactly the one clock cycle after that step.
- R3: In PWM mode, `pwm_out` goes high in the same cycle as `period_strobe`, provided the newly latched duty is non-zero.
- R4: With latched duty D, `pwm_out` stays high while the time base runs from 0 to D−1, which is D steps. It drops in the cycle after the step that brings the time base to D.
- R5: `ctrl_data[5:4]` are the two low duty bits and `duty_data[7:0]` are the high eight, so D = duty·4 + ctrl[5:4]. `ctrl_data[3:0]` is the mode field. PWM mode is active when bits 3 and 2 are both 1, whatever the values of bits 1:0.
- R6: The slave duty is loaded from the master only at a period end. A duty write made mid-period, or in the very cycle of the period end, first takes effect in the following period.
- R7: If D ≥ 4·(P+1), `pwm_out` stays high for the whole period.
- R8: If the latched duty is 0, `pwm_out` stays low for the whole period.
- R9: Leaving PWM mode drives `pwm_out` low from the cycle after the control write. The time base and `period_strobe` keep running. After PWM mode is selected again, the output stays low until the next period start.
- R10: If the period is lowered below the current coarse count, the time base runs on to 1023 and wraps to 0. This wrap raises no strobe and does not reload the duty.
- R11: While `step_en` is low, the time base holds. `pwm_out` holds too, except when it is forced low by R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance the time base by one this cycle |
| period_wr | input | 1 | Write strobe for the period value |
| period_data | input | 8 | Period value P |
| duty_wr | input | 1 | Write strobe for the duty high part (master) |
| duty_data | input | 8 | Duty bits 9:2 |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_data | input | 6 | [5:4] duty bits 1:0, [3:0] mode field |
| pwm_out | output | 1 | PWM output |
| period_strobe | output | 1 | One-cycle pulse at each period start |

## Verification
The hardest situation to reach is a duty write that lands in exactly the cycle in which the period ends. A write one cycle earlier or later exercises a different path. The bench drives the block against a behavioural model of the time base, so it knows in advance which edge closes the period. It raises `duty_wr` at the negative edge just before that edge, then measures the high time of that period and of the next. A second hard case is lowering the period below the running count. The bench waits until the model's coarse count passes a chosen value and then writes the smaller period, which forces the full 1024-step wrap.

// File: rtl/pwm10_pkg.sv
// Package: shared mode encoding for the double-buffered PWM generator.
// Assumes a 4-bit mode field; PWM is selected by the two upper mode bits.
package pwm10_pkg;
    localparam int MODE_W = 4;
    typedef logic [MODE_W-1:0] mode_t;
    localparam mode_t MODE_MASK = 4'b1100;
    localparam mode_t MODE_PWM  = 4'b1100;
endpackage

// File: rtl/pwm10_timebase.sv
// Time base: holds the period value and a 10-bit counter (coarse count plus
// sub-count), flags the period-end step and registers the period strobe.
// Assumes SUB_W >= 1; period writes act immediately (not double-buffered).
module pwm10_timebase #(
    parameter int CNT_W = 8,
    parameter int SUB_W = 2,
    localparam int TB_W = CNT_W + SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             period_wr,
    input  logic [CNT_W-1:0] period_data,
    output logic [TB_W-1:0]  tb_q,
    output logic [TB_W-1:0]  tb_inc,
    output logic             wrap_evt,
    output logic             strobe_q
);
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] coarse;
    logic [SUB_W-1:0] sub;

    // Split the time base into its coarse and sub-count parts.
    assign coarse = tb_q[TB_W-1:SUB_W];
    assign sub    = tb_q[SUB_W-1:0];
    assign tb_inc = tb_q + TB_W'(1);

    // Period end: last sub-step of the coarse count equal to the period.
    assign wrap_evt = step_en && (&sub) && (coarse == period_q);

    // Period register, written directly.
    always_ff @(posedge clk) begin
        if (!rst_n)         period_q <= '0;
        else if (period_wr) period_q <= period_data;
    end

    // Counter: clear at period end, advance on each step, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        tb_q <= '0;
        else if (wrap_evt) tb_q <= '0;
        else if (step_en)  tb_q <= tb_inc;
    end

    // One-cycle strobe in the first cycle of each new period.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= wrap_evt;
    end
endmodule

// File: rtl/pwm10_duty_buf.sv
// Duty buffer: master duty (high part from the duty write, low part from
// the control word), the slave copy used by the compare, and the mode decode.
// Assumes the slave is loaded only on the period-end step.
module pwm10_duty_buf
    import pwm10_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SUB_W = 2,
    localparam int TB_W   = CNT_W + SUB_W,
    localparam int CTRL_W = SUB_W + MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              duty_wr,
    input  logic [CNT_W-1:0]  duty_data,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_data,
    input  logic              load,
    output logic [TB_W-1:0]   master_duty,
    output logic [TB_W-1:0]   slave_duty,
    output logic              pwm_mode
);
    logic [CNT_W-1:0]  hi_q;
    logic [CTRL_W-1:0] ctrl_q;
    mode_t             mode;

    // Assemble the master duty and decode the mode field.
    assign master_duty = {hi_q, ctrl_q[CTRL_W-1:MODE_W]};
    assign mode        = ctrl_q[MODE_W-1:0];
    assign pwm_mode    = ((mode & MODE_MASK) == MODE_PWM);

    // Duty high-part register.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_q <= '0;
        else if (duty_wr) hi_q <= duty_data;
    end

    // Control word register (low duty bits and mode).
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_data;
    end

    // Slave copy, refreshed only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    slave_duty <= '0;
        else if (load) slave_duty <= master_duty;
    end
endmodule

// File: rtl/pwm10_out_stage.sv
// Output stage: sets the output at period start (non-zero duty), clears it
// when the time base reaches the slave duty, and forces it low outside PWM mode.
// Assumes the time base and slave duty share one width.
module pwm10_out_stage #(
    parameter int TB_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_mode,
    input  logic            step_en,
    input  logic            wrap_evt,
    input  logic [TB_W-1:0] tb_inc,
    input  logic [TB_W-1:0] master_duty,
    input  logic [TB_W-1:0] slave_duty,
    output logic            pwm_out
);
    logic out_q;

    // Output latch: set/reset from period start and duty compare.
    always_ff @(posedge clk) begin
        if (!rst_n)                               out_q <= 1'b0;
        else if (!pwm_mode)                       out_q <= 1'b0;
        else if (wrap_evt)                        out_q <= (master_duty != '0);
        else if (step_en && tb_inc == slave_duty) out_q <= 1'b0;
    end

    // Gate with the mode so a control clear takes effect at once.
    assign pwm_out = out_q & pwm_mode;
endmodule

// File: rtl/pwm10_dbuf.sv
// Top: double-buffered 10-bit PWM generator. Connects the time base, the
// duty buffer and the output stage. Assumes a single clock domain.
module pwm10_dbuf
    import pwm10_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SUB_W = 2,
    localparam int TB_W   = CNT_W + SUB_W,
    localparam int CTRL_W = SUB_W + MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              period_wr,
    input  logic [CNT_W-1:0]  period_data,
    input  logic              duty_wr,
    input  logic [CNT_W-1:0]  duty_data,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_data,
    output logic              pwm_out,
    output logic              period_strobe
);
    logic [TB_W-1:0] tb_q;
    logic [TB_W-1:0] tb_inc;
    logic            wrap_evt;
    logic [TB_W-1:0] master_duty;
    logic [TB_W-1:0] slave_duty;
    logic            pwm_mode;

    pwm10_timebase #(.CNT_W(CNT_W), .SUB_W(SUB_W)) i_tb (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .period_wr(period_wr), .period_data(period_data),
        .tb_q(tb_q), .tb_inc(tb_inc), .wrap_evt(wrap_evt),
        .strobe_q(period_strobe)
    );

    pwm10_duty_buf #(.CNT_W(CNT_W), .SUB_W(SUB_W)) i_duty (
        .clk(clk), .rst_n(rst_n),
        .duty_wr(duty_wr), .duty_data(duty_data),
        .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .load(wrap_evt), .master_duty(master_duty),
        .slave_duty(slave_duty), .pwm_mode(pwm_mode)
    );

    pwm10_out_stage #(.TB_W(TB_W)) i_out (
        .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode),
        .step_en(step_en), .wrap_evt(wrap_evt), .tb_inc(tb_inc),
        .master_duty(master_duty), .slave_duty(slave_duty),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/pwm10_dbuf_chk.sv
// Checker: temporal properties of the PWM generator, bound to the top.
module pwm10_dbuf_chk #(
    parameter int TB_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            step_en,
    input logic            pwm_out,
    input logic            period_strobe,
    input logic            pwm_mode,
    input logic [TB_W-1:0] slave_duty,
    input logic [TB_W-1:0] tb_q
);
    // R2: the strobe lasts exactly one cycle.
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        period_strobe |=> !period_strobe);

    // R3: the output only rises at a period start.
    p_rise_with_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> period_strobe);

    // R9: no output outside PWM mode.
    p_low_outside_pwm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_mode |-> !pwm_out);

    // R8: zero latched duty means a low output.
    p_zero_duty_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_duty == '0) |-> !pwm_out);

    // R6: the slave duty changes only at a period boundary.
    p_reload_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slave_duty) |-> period_strobe);

    // R11: the time base holds without a step.
    p_hold_timebase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(tb_q));

    // R11: the output cannot rise without a step.
    p_no_rise_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> !$rose(pwm_out));
endmodule

bind pwm10_dbuf pwm10_dbuf_chk #(.TB_W(TB_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .pwm_out(pwm_out),
    .period_strobe(period_strobe), .pwm_mode(pwm_mode),
    .slave_duty(slave_duty), .tb_q(tb_q)
);

// File: tb/test_pwm10_dbuf.sv
module test_pwm10_dbuf;
    localparam int CNT_W = 8;
    localparam int SUB_W = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_en = 1'b0;
    logic       period_wr = 1'b0;
    logic [7:0] period_data = '0;
    logic       duty_wr = 1'b0;
    logic [7:0] duty_data = '0;
    logic       ctrl_wr = 1'b0;
    logic [5:0] ctrl_data = '0;
    logic       pwm_out;
    logic       period_strobe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    string phase_tag = "R1";

    // Reference model state
    int m_tb = 0, m_per = 0, m_hi = 0, m_ctl = 0, m_slave = 0;
    bit m_out = 0, m_strobe = 0;

    always #10 clk = ~clk;

    pwm10_dbuf #(.CNT_W(CNT_W), .SUB_W(SUB_W)) i_pwm10_dbuf (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .period_wr(period_wr), .period_data(period_data),
        .duty_wr(duty_wr), .duty_data(duty_data),
        .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .pwm_out(pwm_out), .period_strobe(period_strobe)
    );

    function automatic bit is_pwm(int c);
        return ((c >> 2) & 3) == 3;
    endfunction

    task automatic check(string tag, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_tb = 0; m_per = 0; m_hi = 0; m_ctl = 0; m_slave = 0;
            m_out = 0; m_strobe = 0;
        end else begin
            bit wrap;
            int master;
            wrap   = step_en && (m_tb % 4 == 3) && (m_tb / 4 == m_per);
            master = m_hi * 4 + ((m_ctl >> 4) & 3);
            if (!is_pwm(m_ctl))                                m_out = 0;
            else if (wrap)                                     m_out = (master != 0);
            else if (step_en && ((m_tb + 1) % 1024 == m_slave)) m_out = 0;
            if (wrap) m_slave = master;
            if (wrap)         m_tb = 0;
            else if (step_en) m_tb = (m_tb + 1) % 1024;
            m_strobe = wrap;
            if (period_wr) m_per = period_data;
            if (duty_wr)   m_hi  = duty_data;
            if (ctrl_wr)   m_ctl = ctrl_data;
        end
        if (cyc > 150000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit eo;
            eo = m_out && is_pwm(m_ctl);
            check(phase_tag, pwm_out == eo, pwm_out, eo);
            check(phase_tag, period_strobe == m_strobe, period_strobe, m_strobe);
        end
    end

    task automatic wr_period(int v);
        @(negedge clk); period_wr = 1; period_data = v[7:0];
        @(negedge clk); period_wr = 0;
    endtask
    task automatic wr_duty(int v);
        @(negedge clk); duty_wr = 1; duty_data = v[7:0];
        @(negedge clk); duty_wr = 0;
    endtask
    task automatic wr_ctrl(int lo, int mode);
        @(negedge clk); ctrl_wr = 1; ctrl_data = {lo[1:0], mode[3:0]};
        @(negedge clk); ctrl_wr = 0;
    endtask

    // Count from the current (strobe) cycle up to the next strobe.
    task automatic count_to_next(output int clocks, output int highs);
        clocks = 0; highs = 0;
        do begin
            clocks++;
            if (pwm_out) highs++;
            @(negedge clk);
            duty_wr = 0; ctrl_wr = 0; period_wr = 0;
        end while (!period_strobe && clocks < 5000);
    endtask

    task automatic measure(output int clocks, output int highs);
        do @(negedge clk); while (!period_strobe);
        count_to_next(clocks, highs);
    endtask

    initial begin
        int c, h, n;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", pwm_out == 0, pwm_out, 0);
        check("R1", period_strobe == 0, period_strobe, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", pwm_out == 0 && period_strobe == 0, pwm_out, 0);

        // R2/R3/R4/R5: P=3 (16 steps), D = 2*4+1 = 9
        phase_tag = "R4";
        wr_period(3); wr_duty(2); wr_ctrl(1, 4'b1100);
        step_en = 1;
        measure(c, h);
        measure(c, h);
        check("R2", c == 16, c, 16);
        check("R4", h == 9, h, 9);
        // R5: mode bits 1:0 ignored, 4'b0100 is not PWM
        phase_tag = "R5";
        wr_ctrl(1, 4'b1111);
        measure(c, h); measure(c, h);
        check("R5", h == 9, h, 9);
        wr_ctrl(1, 4'b0100);
        measure(c, h);
        check("R5", h == 0, h, 0);
        wr_ctrl(1, 4'b1100);
        measure(c, h);

        // R6: write in the period-end cycle is deferred
        phase_tag = "R6";
        do @(negedge clk); while (!(m_tb == m_per * 4 + 3));
        duty_wr = 1; duty_data = 8'd1;  // D becomes 5
        @(negedge clk); duty_wr = 0;
        check("R6", period_strobe == 1, period_strobe, 1);
        count_to_next(c, h);
        check("R6", h == 9, h, 9);
        // Mid-period write: current period keeps 5, next gets 13
        duty_wr = 1; duty_data = 8'd3;
        count_to_next(c, h);
        check("R6", h == 5, h, 5);
        count_to_next(c, h);
        check("R6", h == 13, h, 13);

        // R7: duty at and above period length; R4 boundary one below
        phase_tag = "R7";
        wr_duty(10);
        measure(c, h); measure(c, h);
        check("R7", h == 16, h, 16);
        wr_duty(4); wr_ctrl(0, 4'b1100);
        measure(c, h); measure(c, h);
        check("R7", h == 16, h, 16);
        wr_duty(3); wr_ctrl(3, 4'b1100);
        measure(c, h); measure(c, h);
        check("R4", h == 15, h, 15);

        // R8: zero duty
        phase_tag = "R8";
        wr_duty(0); wr_ctrl(0, 4'b1100);
        measure(c, h); measure(c, h);
        check("R8", h == 0, h, 0);
        check("R8", c == 16, c, 16);

        // R9: leave PWM mode mid-period, re-enter mid-period
        phase_tag = "R9";
        wr_duty(2); wr_ctrl(1, 4'b1100);
        measure(c, h); measure(c, h);
        do @(negedge clk); while (!period_strobe);
        @(negedge clk);
        ctrl_wr = 1; ctrl_data = 6'b000000;
        @(negedge clk); ctrl_wr = 0;
        check("R9", pwm_out == 0, pwm_out, 0);
        measure(c, h);
        check("R9", c == 16, c, 16);
        check("R9", h == 0, h, 0);
        @(negedge clk); @(negedge clk);
        ctrl_wr = 1; ctrl_data = 6'b011100;
        @(negedge clk); ctrl_wr = 0;
        check("R9", pwm_out == 0, pwm_out, 0);
        count_to_next(c, h);
        check("R9", h == 0, h, 0);
        count_to_next(c, h);
        check("R9", h == 9, h, 9);

        // R10: lower period below running count
        phase_tag = "R10";
        wr_period(40);
        do @(negedge clk); while (m_tb / 4 != 30);
        period_wr = 1; period_data = 8'd5;
        @(negedge clk); period_wr = 0;
        n = 0;
        do begin
            if (period_strobe) n++;
            @(negedge clk);
        end while (m_tb != 0);
        check("R10", n == 0, n, 0);
        measure(c, h);
        check("R10", c == 24, c, 24);

        // R11: stepping every other cycle
        phase_tag = "R11";
        wr_period(3);
        measure(c, h);
        fork
            begin
                for (int i = 0; i < 200; i++) begin
                    @(negedge clk); step_en = (i % 2 == 0);
                end
            end
            begin
                measure(c, h); measure(c, h);
            end
        join
        check("R11", c == 32, c, 32);
        check("R11", h == 18, h, 18);
        step_en = 1;

        // R2: random stimulus against the model
        phase_tag = "R2";
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            step_en   = ($urandom % 4) != 0;
            period_wr = ($urandom % 97) == 0;
            period_data = 8'($urandom % 12);
            duty_wr   = ($urandom % 31) == 0;
            duty_data = 8'($urandom % 14);
            ctrl_wr   = ($urandom % 53) == 0;
            ctrl_data = {2'($urandom), (($urandom % 4) == 0) ? 4'b0001 : 4'b1100 | 4'($urandom % 4)};
        end
        @(negedge clk);
        period_wr = 0; duty_wr = 0; ctrl_wr = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule